// File: doc/BRIEF.md
# Timing-Token Endpoint Bridge

This block connects one ready/valid target port to a token-driven simulation. Every advance of target time is one token exchange. The target wrapper offers one token describing the target's cycle: whether it is producing an output transaction, that transaction's data, and whether it can accept an input transaction. The bridge returns one token that tells the target what it sees in that cycle: a pending input transaction and whether its output will be accepted. A third channel carries one reset token per target cycle. Target time moves only when all three tokens and a nonzero step budget are present together, so host delays never change what the target sees.

Host software uses a small register bus. Through it the host grants a budget of target cycles, reads status, feeds input transactions into a buffer and drains output transactions from a second buffer. Transactions that are wider than the bus are moved as several bus words, least significant word first. The host polls the done flag to learn that the granted cycles have elapsed and that no input transaction is still waiting.

Top module: `tkb_bridge`

## Requirements
- R1: An exchange (fire) happens in a cycle only when `tgt_tok_valid`, `drv_tok_ready` and `rst_tok_valid` are all 1 and the step budget is nonzero; `drv_tok_valid`, `tgt_tok_ready` and `rst_tok_ready` are all equal to fire.
- R2: `drv_tok_xv` is 1 when the input buffer holds an entry and `rst_tok_val` is 0; `drv_tok_xrdy` is 1 when the output buffer is not full and `rst_tok_val` is 0.
- R3: On a fire with `drv_tok_xv` and `tgt_tok_xrdy` both 1, the input buffer's oldest entry is removed.
- R4: On a fire with `tgt_tok_xv` and `drv_tok_xrdy` both 1, `tgt_tok_xdata` is appended to the output buffer.
- R5: A fire with `rst_tok_val` = 1 empties both buffers.
- R6: A write to address 0x0 loads the step budget from the low STEP_W bits of the write data; each fire lowers it by one; a budget of zero prevents fire. A write wins over a same-cycle decrement.
- R7: A read of address 0x4 returns status with bit 0 = done, bit 1 = input buffer full, bit 2 = output buffer empty, other bits 0. Every read's data appears on `reg_rdata` in the cycle after `reg_rd`.
- R8: Writes to address 0x8 collect ceil(DATA_W/BUS_W) words, least significant first; the last word enqueues the assembled value, which is dropped if the input buffer is full at that write. `drv_tok_xdata` shows the oldest input entry.
- R9: Reads of address 0xC return the oldest output entry one word at a time, least significant first; the read of the last word removes the entry. A read while the output buffer is empty returns 0 and changes nothing.
- R10: `done` is 1 exactly when the step budget is zero and the input buffer is empty.
- R11: Writes to any address other than 0x0 and 0x8, and reads of any address other than 0x4 and 0xC, change no state; such reads return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_tok_valid | input | 1 | Target offers its cycle token |
| tgt_tok_ready | output | 1 | Target token consumed (fire) |
| tgt_tok_xv | input | 1 | Target output transaction valid in this cycle |
| tgt_tok_xdata | input | DATA_W | Target output transaction data |
| tgt_tok_xrdy | input | 1 | Target accepts an input transaction in this cycle |
| drv_tok_valid | output | 1 | Token toward the target produced (fire) |
| drv_tok_ready | input | 1 | Target can take a token |
| drv_tok_xv | output | 1 | Input transaction presented to the target |
| drv_tok_xdata | output | DATA_W | Input transaction data |
| drv_tok_xrdy | output | 1 | Target output transaction will be accepted |
| rst_tok_valid | input | 1 | Reset token present |
| rst_tok_ready | output | 1 | Reset token consumed (fire) |
| rst_tok_val | input | 1 | Reset token value |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | BUS_W | Register write data |
| reg_rdata | output | BUS_W | Register read data, one cycle after the read |
| done | output | 1 | Budget spent and no input pending |

## Verification
The buffer assertions take for granted that the wrapper's token fields follow the presented flags, that is, the bridge pushes or pops only when its own ready and valid flags said it could, which the stimulus cannot break because those flags come from the bridge itself. The step assertions assume a register write and a fire may coincide, and the stimulus drives exactly that case as well as long stretches of random token gaps, reset tokens and interleaved bus traffic. Flushes are issued while partial words are idle so the word counters stay aligned with the reference queues.

// File: rtl/tkb_pkg.sv
package tkb_pkg;

  localparam int OFS_STEP = 0;
  localparam int OFS_STAT = 4;
  localparam int OFS_IN   = 8;
  localparam int OFS_OUT  = 12;

  typedef struct packed {
    logic out_empty;
    logic in_full;
    logic done;
  } status_t;

  localparam int STAT_W = $bits(status_t);

endpackage

// File: rtl/tkb_fifo.sv
module tkb_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign head  = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_d = cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_q] <= wdata;
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R4
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R3

endmodule

// File: rtl/tkb_fire.sv
module tkb_fire #(
  parameter int DATA_W = 64
) (
  input  logic              tgt_tok_valid,
  input  logic              drv_tok_ready,
  input  logic              rst_tok_valid,
  input  logic              rst_tok_val,
  input  logic              budget_ok,
  input  logic              in_empty,
  input  logic [DATA_W-1:0] in_head,
  input  logic              out_full,
  input  logic              tgt_xv,
  input  logic              tgt_xrdy,
  output logic              fire,
  output logic              drv_xv,
  output logic [DATA_W-1:0] drv_xdata,
  output logic              drv_xrdy,
  output logic              in_pop,
  output logic              out_push,
  output logic              flush
);

  always_comb begin
    fire      = tgt_tok_valid && drv_tok_ready && rst_tok_valid && budget_ok;
    drv_xv    = !in_empty && !rst_tok_val;
    drv_xdata = in_head;
    drv_xrdy  = !out_full && !rst_tok_val;
    in_pop    = fire && drv_xv && tgt_xrdy;
    out_push  = fire && tgt_xv && drv_xrdy;
    flush     = fire && rst_tok_val;
  end

endmodule

// File: rtl/tkb_regs.sv
module tkb_regs
  import tkb_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 4,
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic              fire,
  input  logic              in_full,
  input  logic              in_empty,
  input  logic              out_empty,
  input  logic [DATA_W-1:0] out_head,
  output logic              in_push,
  output logic [DATA_W-1:0] in_wdata,
  output logic              out_pop,
  output logic              budget_ok,
  output logic              done
);

  localparam int WORDS = (DATA_W + BUS_W - 1) / BUS_W;
  localparam int IW    = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int PN    = (WORDS > 1) ? WORDS - 1 : 1;
  localparam int FW    = WORDS * BUS_W;

  logic              wr_step, wr_in, rd_stat, rd_out;
  logic              wr_last, rd_last;
  logic [IW-1:0]     wr_idx_q, wr_idx_d, rd_idx_q, rd_idx_d;
  logic [BUS_W-1:0]  part_q [PN];
  logic [FW-1:0]     asm_vec, head_pad;
  logic [STEP_W-1:0] steps_q, steps_d;
  logic [BUS_W-1:0]  rdata_q, rdata_d;
  status_t           stat;

  assign wr_step = reg_wr && (reg_addr == ADDR_W'(OFS_STEP));
  assign wr_in   = reg_wr && (reg_addr == ADDR_W'(OFS_IN));
  assign rd_stat = reg_rd && (reg_addr == ADDR_W'(OFS_STAT));
  assign rd_out  = reg_rd && (reg_addr == ADDR_W'(OFS_OUT));

  assign wr_last = (wr_idx_q == IW'(WORDS - 1));
  assign rd_last = (rd_idx_q == IW'(WORDS - 1));

  assign budget_ok = (steps_q != '0);
  assign done      = !budget_ok && in_empty;
  assign in_push   = wr_in && wr_last && !in_full;
  assign out_pop   = rd_out && !out_empty && rd_last;
  assign reg_rdata = rdata_q;

  // assemble the incoming wide value from stored words plus the current one
  always_comb begin
    asm_vec = '0;
    for (int k = 0; k < WORDS - 1; k++) begin
      asm_vec[k*BUS_W +: BUS_W] = part_q[k];
    end
    asm_vec[(WORDS-1)*BUS_W +: BUS_W] = reg_wdata;
    in_wdata = asm_vec[DATA_W-1:0];
  end

  always_comb begin
    head_pad = '0;
    head_pad[DATA_W-1:0] = out_head;
  end

  always_comb begin
    stat.done      = done;
    stat.in_full   = in_full;
    stat.out_empty = out_empty;
  end

  always_comb begin
    wr_idx_d = wr_idx_q;
    rd_idx_d = rd_idx_q;
    steps_d  = steps_q;
    rdata_d  = '0;
    if (wr_in)                  wr_idx_d = wr_last ? '0 : wr_idx_q + 1'b1;
    if (rd_out && !out_empty)   rd_idx_d = rd_last ? '0 : rd_idx_q + 1'b1;
    if (wr_step)                steps_d  = reg_wdata[STEP_W-1:0];
    else if (fire)              steps_d  = steps_q - 1'b1;
    if (rd_stat)                rdata_d[STAT_W-1:0] = stat;
    if (rd_out && !out_empty)   rdata_d = head_pad[rd_idx_q*BUS_W +: BUS_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      steps_q  <= '0;
      rdata_q  <= '0;
    end else begin
      wr_idx_q <= wr_idx_d;
      rd_idx_q <= rd_idx_d;
      steps_q  <= steps_d;
      if (reg_rd) rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_in && !wr_last) part_q[wr_idx_q] <= reg_wdata;
  end

  AST_BUDGET_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (steps_q == '0) |-> !fire); // R6
  AST_STEP_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wr_step) |=> (steps_q == $past(steps_q) - 1'b1)); // R6
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_out && out_empty) |=> (reg_rdata == '0)); // R9

endmodule

// File: rtl/tkb_bridge.sv
module tkb_bridge #(
  parameter int DATA_W = 64,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 4,
  parameter int STEP_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tgt_tok_valid,
  output logic              tgt_tok_ready,
  input  logic              tgt_tok_xv,
  input  logic [DATA_W-1:0] tgt_tok_xdata,
  input  logic              tgt_tok_xrdy,
  output logic              drv_tok_valid,
  input  logic              drv_tok_ready,
  output logic              drv_tok_xv,
  output logic [DATA_W-1:0] drv_tok_xdata,
  output logic              drv_tok_xrdy,
  input  logic              rst_tok_valid,
  output logic              rst_tok_ready,
  input  logic              rst_tok_val,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic              done
);

  logic              fire, flush, budget_ok;
  logic              in_push, in_pop, in_full, in_empty;
  logic              out_push, out_pop, out_full, out_empty;
  logic [DATA_W-1:0] in_wdata, in_head, out_head;

  assign tgt_tok_ready = fire;
  assign drv_tok_valid = fire;
  assign rst_tok_ready = fire;

  tkb_fire #(.DATA_W(DATA_W)) fire_i (
    .tgt_tok_valid (tgt_tok_valid),
    .drv_tok_ready (drv_tok_ready),
    .rst_tok_valid (rst_tok_valid),
    .rst_tok_val   (rst_tok_val),
    .budget_ok     (budget_ok),
    .in_empty      (in_empty),
    .in_head       (in_head),
    .out_full      (out_full),
    .tgt_xv        (tgt_tok_xv),
    .tgt_xrdy      (tgt_tok_xrdy),
    .fire          (fire),
    .drv_xv        (drv_tok_xv),
    .drv_xdata     (drv_tok_xdata),
    .drv_xrdy      (drv_tok_xrdy),
    .in_pop        (in_pop),
    .out_push      (out_push),
    .flush         (flush)
  );

  tkb_fifo #(.W(DATA_W), .DEPTH(DEPTH)) in_buf_i (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (in_push),
    .pop   (in_pop),
    .wdata (in_wdata),
    .head  (in_head),
    .full  (in_full),
    .empty (in_empty)
  );

  tkb_fifo #(.W(DATA_W), .DEPTH(DEPTH)) out_buf_i (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (out_push),
    .pop   (out_pop),
    .wdata (tgt_tok_xdata),
    .head  (out_head),
    .full  (out_full),
    .empty (out_empty)
  );

  tkb_regs #(
    .DATA_W (DATA_W),
    .BUS_W  (BUS_W),
    .ADDR_W (ADDR_W),
    .STEP_W (STEP_W)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .fire      (fire),
    .in_full   (in_full),
    .in_empty  (in_empty),
    .out_empty (out_empty),
    .out_head  (out_head),
    .in_push   (in_push),
    .in_wdata  (in_wdata),
    .out_pop   (out_pop),
    .budget_ok (budget_ok),
    .done      (done)
  );

  AST_TOKENS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    drv_tok_valid |-> (tgt_tok_valid && drv_tok_ready && rst_tok_valid)); // R1
  AST_RESET_TOKEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_tok_val |-> (!drv_tok_xv && !drv_tok_xrdy)); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_tok_valid && rst_tok_val) |=> (in_empty && out_empty)); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !drv_tok_valid); // R10

endmodule

// File: tb/tkb_bridge_tb_top.sv
module tkb_bridge_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 64;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 4;
  localparam int STEP_W = 16;
  localparam int DEPTH  = 4;
  localparam int WORDS  = (DATA_W + BUS_W - 1) / BUS_W;
  localparam int FW     = WORDS * BUS_W;
  localparam int WDOG   = 20000;

  logic              clk, rst_n;
  logic              tgt_tok_valid, tgt_tok_ready, tgt_tok_xv, tgt_tok_xrdy;
  logic [DATA_W-1:0] tgt_tok_xdata;
  logic              drv_tok_valid, drv_tok_ready, drv_tok_xv, drv_tok_xrdy;
  logic [DATA_W-1:0] drv_tok_xdata;
  logic              rst_tok_valid, rst_tok_ready, rst_tok_val;
  logic              reg_wr, reg_rd, done;
  logic [ADDR_W-1:0] reg_addr;
  logic [BUS_W-1:0]  reg_wdata, reg_rdata;

  int n_chk = 0, n_bad = 0, n_fire = 0, n_pop = 0, cyc = 0;

  // reference model state
  logic [DATA_W-1:0] m_in [$];
  logic [DATA_W-1:0] m_out [$];
  logic [BUS_W-1:0]  m_part [WORDS];
  int                m_steps = 0, m_wr_idx = 0, m_rd_idx = 0;
  logic              m_rd_pend = 1'b0;
  logic [BUS_W-1:0]  m_rd_exp = '0;
  string             m_rd_tag = "R7";

  tkb_bridge #(
    .DATA_W(DATA_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .STEP_W(STEP_W), .DEPTH(DEPTH)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .tgt_tok_valid(tgt_tok_valid), .tgt_tok_ready(tgt_tok_ready),
    .tgt_tok_xv(tgt_tok_xv), .tgt_tok_xdata(tgt_tok_xdata), .tgt_tok_xrdy(tgt_tok_xrdy),
    .drv_tok_valid(drv_tok_valid), .drv_tok_ready(drv_tok_ready),
    .drv_tok_xv(drv_tok_xv), .drv_tok_xdata(drv_tok_xdata), .drv_tok_xrdy(drv_tok_xrdy),
    .rst_tok_valid(rst_tok_valid), .rst_tok_ready(rst_tok_ready), .rst_tok_val(rst_tok_val),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WDOG);
      summary();
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one target-clock step: compare, advance the model, cross the edge
  task automatic cycle();
    logic f, txv, ordy, mdone, pop_in, push_in, pop_out, push_out;
    logic [BUS_W-1:0]  rd_nx;
    logic [FW-1:0]     tmp;
    logic [DATA_W-1:0] new_in;
    string             tag;
    #1;
    f     = tgt_tok_valid && drv_tok_ready && rst_tok_valid && (m_steps != 0);
    txv   = (m_in.size() != 0) && !rst_tok_val;
    ordy  = (m_out.size() < DEPTH) && !rst_tok_val;
    mdone = (m_steps == 0) && (m_in.size() == 0);
    chk("R1", 64'(drv_tok_valid), 64'(f));
    chk("R1", 64'(tgt_tok_ready), 64'(f));
    chk("R1", 64'(rst_tok_ready), 64'(f));
    chk("R2", 64'(drv_tok_xv), 64'(txv));
    chk("R2", 64'(drv_tok_xrdy), 64'(ordy));
    if (txv) chk("R8", 64'(drv_tok_xdata), 64'(m_in[0]));
    chk("R10", 64'(done), 64'(mdone));
    if (m_rd_pend) chk(m_rd_tag, 64'(reg_rdata), 64'(m_rd_exp));
    if (drv_tok_valid) n_fire++;
    if (drv_tok_valid && drv_tok_xv && tgt_tok_xrdy) n_pop++;

    rd_nx = '0;
    tag   = "R11";
    if (reg_rd && reg_addr == 4'h4) begin
      tag = "R7";
      rd_nx[0] = mdone;
      rd_nx[1] = (m_in.size() == DEPTH);
      rd_nx[2] = (m_out.size() == 0);
    end else if (reg_rd && reg_addr == 4'hC) begin
      tag = "R9";
      if (m_out.size() != 0) begin
        tmp = '0;
        tmp[DATA_W-1:0] = m_out[0];
        rd_nx = tmp[m_rd_idx*BUS_W +: BUS_W];
      end
    end
    m_rd_pend = reg_rd;
    m_rd_exp  = rd_nx;
    m_rd_tag  = tag;

    pop_out = 1'b0;
    if (reg_rd && reg_addr == 4'hC && m_out.size() != 0) begin
      if (m_rd_idx == WORDS - 1) begin
        pop_out  = 1'b1;
        m_rd_idx = 0;
      end else m_rd_idx++;
    end
    push_in = 1'b0;
    new_in  = '0;
    if (reg_wr && reg_addr == 4'h8) begin
      m_part[m_wr_idx] = reg_wdata;
      if (m_wr_idx == WORDS - 1) begin
        m_wr_idx = 0;
        if (m_in.size() < DEPTH) begin
          push_in = 1'b1;
          tmp = '0;
          for (int k = 0; k < WORDS; k++) tmp[k*BUS_W +: BUS_W] = m_part[k];
          new_in = tmp[DATA_W-1:0];
        end
      end else m_wr_idx++;
    end
    pop_in   = f && txv && tgt_tok_xrdy;
    push_out = f && tgt_tok_xv && ordy;
    if (pop_out)  void'(m_out.pop_front());
    if (pop_in)   void'(m_in.pop_front());
    if (push_in)  m_in.push_back(new_in);
    if (push_out) m_out.push_back(tgt_tok_xdata);
    if (f && rst_tok_val) begin
      m_in.delete();
      m_out.delete();
    end
    if (reg_wr && reg_addr == 4'h0) m_steps = int'(reg_wdata[STEP_W-1:0]);
    else if (f) m_steps--;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cycle();
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a);
    reg_rd = 1'b1; reg_addr = a;
    cycle();
    reg_rd = 1'b0;
  endtask

  task automatic tokens(input logic tv, input logic dr, input logic rv, input logic rb);
    tgt_tok_valid = tv; drv_tok_ready = dr; rst_tok_valid = rv; rst_tok_val = rb;
  endtask

  initial begin
    rst_n = 1'b0;
    tokens(0, 0, 0, 0);
    tgt_tok_xv = 0; tgt_tok_xdata = '0; tgt_tok_xrdy = 0;
    reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // reset state, budget zero blocks fire
    tokens(1, 1, 1, 0);
    idle(1);
    chk("R10", 64'(done), 64'd1);
    bus_rd(4'h4);
    chk("R7", 64'(reg_rdata), 64'h5);

    // budget of three
    n_fire = 0;
    bus_wr(4'h0, 32'd3);
    idle(5);
    chk("R6", 64'(n_fire), 64'd3);

    // two-word input transaction
    tokens(1, 1, 0, 0);
    bus_wr(4'h8, 32'h1111_2222);
    bus_wr(4'h8, 32'h0000_ABCD);
    chk("R8", 64'(drv_tok_xv), 64'd1);
    chk("R8", 64'(drv_tok_xdata), 64'h0000_ABCD_1111_2222);
    chk("R10", 64'(done), 64'd0);

    // target takes it
    tokens(1, 1, 1, 0);
    tgt_tok_xrdy = 1;
    bus_wr(4'h0, 32'd1);
    idle(1);
    chk("R3", 64'(drv_tok_xv), 64'd0);

    // target emits one output transaction
    tgt_tok_xrdy = 0;
    tgt_tok_xv = 1; tgt_tok_xdata = 64'h0123_4567_89AB_CDEF;
    bus_wr(4'h0, 32'd1);
    idle(1);
    tgt_tok_xv = 0;
    bus_rd(4'h4);
    chk("R4", 64'(reg_rdata), 64'h1);
    bus_rd(4'hC);
    chk("R9", 64'(reg_rdata), 64'h89AB_CDEF);
    bus_rd(4'hC);
    chk("R9", 64'(reg_rdata), 64'h0123_4567);
    bus_rd(4'h4);
    chk("R9", 64'(reg_rdata), 64'h5);
    bus_rd(4'hC);
    chk("R9", 64'(reg_rdata), 64'h0);

    // overfill the input buffer: fifth entry is dropped
    tokens(1, 1, 0, 0);
    for (int e = 0; e < DEPTH + 1; e++) begin
      bus_wr(4'h8, 32'(e + 16));
      bus_wr(4'h8, 32'(e + 32));
    end
    bus_rd(4'h4);
    chk("R8", 64'(reg_rdata), 64'h6);
    tokens(1, 1, 1, 0);
    tgt_tok_xrdy = 1;
    n_pop = 0;
    bus_wr(4'h0, 32'd8);
    idle(9);
    chk("R8", 64'(n_pop), 64'(DEPTH));

    // reset token flushes both buffers
    tgt_tok_xrdy = 0;
    tokens(1, 1, 0, 0);
    bus_wr(4'h8, 32'hAAAA_0001); bus_wr(4'h8, 32'hAAAA_0002);
    bus_wr(4'h8, 32'hBBBB_0001); bus_wr(4'h8, 32'hBBBB_0002);
    tokens(1, 1, 1, 0);
    tgt_tok_xv = 1; tgt_tok_xdata = 64'hFEED_0000_0000_BEEF;
    bus_wr(4'h0, 32'd1);
    idle(1);
    tgt_tok_xv = 0;
    tokens(1, 1, 1, 1);
    #1;
    chk("R2", 64'(drv_tok_xv), 64'd0);
    bus_wr(4'h0, 32'd1);
    idle(1);
    tokens(1, 1, 1, 0);
    bus_rd(4'h4);
    chk("R5", 64'(reg_rdata), 64'h5);

    // unmapped accesses have no effect
    bus_wr(4'h4, 32'hFFFF_FFFF);
    bus_wr(4'hC, 32'hFFFF_FFFF);
    bus_wr(4'h2, 32'hFFFF_FFFF);
    bus_rd(4'h0);
    chk("R11", 64'(reg_rdata), 64'h0);
    bus_rd(4'h8);
    chk("R11", 64'(reg_rdata), 64'h0);
    bus_rd(4'h4);
    chk("R11", 64'(reg_rdata), 64'h5);
    chk("R11", 64'(drv_tok_valid), 64'd0);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int op;
      tokens(($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0,
             ($urandom % 40) == 0);
      tgt_tok_xv    = $urandom % 2;
      tgt_tok_xdata = {$urandom, $urandom};
      tgt_tok_xrdy  = $urandom % 2;
      op = $urandom % 9;
      case (op)
        0: begin reg_wr = 1; reg_addr = 4'h0; reg_wdata = 32'($urandom % 7); end
        1, 2: begin reg_wr = 1; reg_addr = 4'h8; reg_wdata = $urandom; end
        3, 4: begin reg_rd = 1; reg_addr = 4'hC; end
        5: begin reg_rd = 1; reg_addr = 4'h4; end
        6: begin reg_wr = 1; reg_addr = 4'(($urandom % 4) * 4 + 2); reg_wdata = $urandom; end
        7: begin reg_rd = 1; reg_addr = 4'h0; end
        default: ;
      endcase
      cycle();
      reg_wr = 0; reg_rd = 0;
    end

    summary();
  end

endmodule